// File: doc/BRIEF.md
# Synchronized Host/Client PWM Generator Set

The block contains a set of edge-aligned PWM generators, three by default, that share one programmed period and one programmed duty. Generator 0 is the host. Once enabled it starts a new cycle at the end of each of its own cycles, so it runs without a break. Every other generator is a client. A client never runs on its own. It starts one cycle when the host starts a cycle, runs that one cycle, and then waits for the next host start. A client that is enabled before the host therefore starts on exactly the same clock as the host. After that all waveforms stay in phase.

Software writes the period and the duty into shadow registers. Both values count in sixteenths of a clock, and only the whole-clock part is used. A write changes nothing on the outputs. It takes effect when an update request is pending and the host starts a cycle. On that clock the shadow values move into one active set that every generator reads. All generators therefore change period and duty together. The pending request then clears by itself.

Top module: `sync_pwm_trio`

## Requirements
- R1: While reset is held and on the first clock after it, every `pwm_out` bit, every `soc_out` bit and `upd_busy` are 0.
- R2: The period and duty inputs are unsigned fixed-point values whose low 4 bits are a fraction that is ignored. A cycle lasts `per_val >> 4` clocks, and consecutive `soc_out` pulses of a running generator are exactly that many clocks apart.
- R3: In each cycle `pwm_out` is high for the first `duty_val >> 4` clocks, counted from the clock on which `soc_out` is high, and low for the rest of the cycle.
- R4: An active duty of 0 keeps the output low for the whole cycle. An active duty equal to or above the active period keeps it high for the whole cycle.
- R5: While the host (bit 0) is enabled, it starts its next cycle on the clock right after its previous cycle ends. When it is disabled, it finishes the current cycle and then holds its output low with no `soc_out` pulses.
- R6: A client (bit 1 and up) starts a cycle only on a clock on which the host starts one. While no host cycle starts, an enabled client keeps its output low and gives no `soc_out` pulse.
- R7: Clients that are enabled while the host starts give their `soc_out` pulse on the same clock as the host. While they run, their `pwm_out` equals the host's `pwm_out` on every clock.
- R8: Shadow writes (`per_wr`, `duty_wr`) do not change the running waveform unless an update request is pending when the host starts a cycle.
- R9: `upd_set` makes `upd_busy` 1. It stays 1 until the host starts a cycle, and that start clears it. If the host is idle, the request stays pending.
- R10: When a pending request is transferred, the host and all running clients switch to the new period and duty in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that drives the counters |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | NUM_GEN | Enable bit for each generator; bit 0 is the host |
| per_wr | input | 1 | Writes `per_val` into the period shadow register |
| per_val | input | CNT_W+FRAC_W | Period in sixteenths of a clock |
| duty_wr | input | 1 | Writes `duty_val` into the duty shadow register |
| duty_val | input | CNT_W+FRAC_W | Duty in sixteenths of a clock |
| upd_set | input | 1 | Requests a transfer of the shadow values at the next host start |
| upd_busy | output | 1 | An update request is pending |
| pwm_out | output | NUM_GEN | Waveform of each generator |
| soc_out | output | NUM_GEN | One-clock pulse on the first clock of each generator's cycle |

## Verification
The assertions check four things on every clock. The count never passes the end of the active period. A cycle-start pulse always marks count zero. The host keeps running while it is enabled, and every client start coincides with a host start. They also check that the active set changes only on a transfer, and that a transfer clears the request. The bench scenarios are needed to show the actual cycle length and high time, the duty edge cases and the lockstep start of clients enabled before the host. They also show that shadow writes stay invisible until a requested transfer, and that a client joining late waits for the host's next start.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
   typedef enum logic {
      ROLE_HOST   = 1'b0,
      ROLE_CLIENT = 1'b1
   } gen_role_e;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
   parameter int CNT_W  = 16,
   parameter int FRAC_W = 4,
   localparam int VAL_W = CNT_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             per_wr,
   input  logic [VAL_W-1:0] per_val,
   input  logic             duty_wr,
   input  logic [VAL_W-1:0] duty_val,
   input  logic             upd_set,
   input  logic             xfer,
   output logic [CNT_W-1:0] act_per,
   output logic [CNT_W-1:0] act_duty,
   output logic             upd_pending
);
   logic [VAL_W-1:0] sh_per, sh_duty;
   logic             take;

   assign take = xfer && upd_pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_per      <= '0;
         sh_duty     <= '0;
         act_per     <= '0;
         act_duty    <= '0;
         upd_pending <= 1'b0;
      end else begin
         if (per_wr)  sh_per  <= per_val;
         if (duty_wr) sh_duty <= duty_val;
         if (take) begin
            act_per  <= sh_per[VAL_W-1 -: CNT_W];
            act_duty <= sh_duty[VAL_W-1 -: CNT_W];
         end
         upd_pending <= upd_set || (upd_pending && !xfer);
      end
   end

   AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !upd_set) |=> !upd_pending);  // R9
   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(act_per) && $stable(act_duty)));  // R8
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
   import sync_pwm_pkg::*;
#(
   parameter int        CNT_W = 16,
   parameter gen_role_e ROLE  = ROLE_CLIENT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             trig,
   input  logic [CNT_W-1:0] per_clk,
   input  logic [CNT_W-1:0] duty_clk,
   output logic             start,
   output logic             soc_pulse,
   output logic             pwm
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             running;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic             eoc;

   assign last = (per_clk == '0) ? '0 : per_clk - ONE;
   assign eoc  = running && (cnt == last);

   generate
      if (ROLE == ROLE_HOST) begin : g_host
         assign start = en && (!running || eoc || trig);
         AST_HOST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            (en && running) |=> running);  // R5
      end else begin : g_client
         assign start = en && trig;
         AST_CLIENT_TRIGGERED: assert property (@(posedge clk) disable iff (!rst_n)
            soc_pulse |-> $past(trig));  // R6
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running   <= 1'b0;
         cnt       <= '0;
         soc_pulse <= 1'b0;
      end else begin
         soc_pulse <= start;
         if (start) begin
            running <= 1'b1;
            cnt     <= '0;
         end else if (eoc) begin
            running <= 1'b0;
            cnt     <= '0;
         end else if (running) begin
            cnt <= cnt + ONE;
         end
      end
   end

   assign pwm = running && (cnt < duty_clk);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt <= last));  // R2
   AST_SOC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      soc_pulse |-> (running && cnt == '0));  // R3
endmodule

// File: rtl/sync_pwm_trio.sv
module sync_pwm_trio
   import sync_pwm_pkg::*;
#(
   parameter int NUM_GEN = 3,
   parameter int CNT_W   = 16,
   parameter int FRAC_W  = 4,
   localparam int VAL_W  = CNT_W + FRAC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_GEN-1:0] gen_en,
   input  logic               per_wr,
   input  logic [VAL_W-1:0]   per_val,
   input  logic               duty_wr,
   input  logic [VAL_W-1:0]   duty_val,
   input  logic               upd_set,
   output logic               upd_busy,
   output logic [NUM_GEN-1:0] pwm_out,
   output logic [NUM_GEN-1:0] soc_out
);
   generate
      if (NUM_GEN < 2) begin : g_bad_num
         $error("sync_pwm_trio: NUM_GEN must be at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("sync_pwm_trio: CNT_W must be at least 2");
      end
      if (FRAC_W < 0) begin : g_bad_frac
         $error("sync_pwm_trio: FRAC_W must not be negative");
      end
   endgenerate

   logic [CNT_W-1:0]   act_per, act_duty;
   logic [NUM_GEN-1:0] starts;
   logic               host_start;

   assign host_start = starts[0];

   pwm_shadow_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .per_wr     (per_wr),
      .per_val    (per_val),
      .duty_wr    (duty_wr),
      .duty_val   (duty_val),
      .upd_set    (upd_set),
      .xfer       (host_start),
      .act_per    (act_per),
      .act_duty   (act_duty),
      .upd_pending(upd_busy)
   );

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      localparam gen_role_e ROLE = (g == 0) ? ROLE_HOST : ROLE_CLIENT;
      pwm_edge_gen #(.CNT_W(CNT_W), .ROLE(ROLE)) u_gen (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (gen_en[g]),
         .trig     ((g == 0) ? 1'b0 : host_start),
         .per_clk  (act_per),
         .duty_clk (act_duty),
         .start    (starts[g]),
         .soc_pulse(soc_out[g]),
         .pwm      (pwm_out[g])
      );
      if (g > 0) begin : g_client_chk
         AST_CLIENT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            starts[g] |-> host_start);  // R6
         AST_CLIENT_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
            soc_out[g] |-> soc_out[0]);  // R7
      end
   end
endmodule

// File: tb/sync_pwm_trio_test.sv
module sync_pwm_trio_test;
   localparam int CLK_PERIOD = 10;
   localparam int NG = 3;
   localparam int VW = 20;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NG-1:0] gen_en;
   logic          per_wr, duty_wr, upd_set;
   logic [VW-1:0] per_val, duty_val;
   logic          upd_busy;
   logic [NG-1:0] pwm_out, soc_out;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_pwm_trio uut (
      .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
      .per_wr(per_wr), .per_val(per_val),
      .duty_wr(duty_wr), .duty_val(duty_val),
      .upd_set(upd_set), .upd_busy(upd_busy),
      .pwm_out(pwm_out), .soc_out(soc_out)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_cfg(input int pc, input int pf, input int dc, input int df,
                            input bit req);
      @(negedge clk);
      per_wr   = 1'b1; per_val  = VW'((pc << 4) | pf);
      duty_wr  = 1'b1; duty_val = VW'((dc << 4) | df);
      upd_set  = req;
      @(negedge clk);
      per_wr = 1'b0; duty_wr = 1'b0; upd_set = 1'b0;
   endtask

   // measures one full cycle of generator g, from one start pulse to the next
   task automatic measure(input int g, output int per, output int hi);
      int guard = 0;
      per = 0; hi = 0;
      while (soc_out[g] && guard < 5000) begin @(negedge clk); guard++; end
      while (!soc_out[g] && guard < 5000) begin @(negedge clk); guard++; end
      do begin
         if (pwm_out[g]) hi++;
         per++;
         @(negedge clk);
      end while (!soc_out[g] && per < 5000);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; gen_en = '0;
      per_wr = 0; duty_wr = 0; upd_set = 0; per_val = '0; duty_val = '0;
      repeat (3) @(negedge clk);
      chk(pwm_out == '0 && soc_out == '0 && upd_busy == 1'b0, "R1", "outputs in reset",
          int'({upd_busy, soc_out, pwm_out}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pwm_out == '0 && soc_out == '0 && upd_busy == 1'b0, "R1", "outputs after reset",
          int'({upd_busy, soc_out, pwm_out}), 0);
   endtask

   task automatic t_start_lockstep();
      int p, h; bit bad = 0;
      write_cfg(10, 15, 4, 9, 1'b1);
      chk(upd_busy == 1'b1, "R9", "busy after request", int'(upd_busy), 1);
      gen_en = 3'b110;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (pwm_out != '0 || soc_out != '0) bad = 1;
      end
      chk(!bad, "R6", "clients idle without host", int'(bad), 0);
      chk(upd_busy == 1'b1, "R9", "busy held while host idle", int'(upd_busy), 1);
      gen_en = 3'b111;
      measure(0, p, h);
      chk(p == 10, "R2", "host period, fraction ignored", p, 10);
      chk(h == 4, "R3", "host high time", h, 4);
      chk(upd_busy == 1'b0, "R9", "request cleared by transfer", int'(upd_busy), 0);
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         if (soc_out != {NG{soc_out[0]}} || pwm_out != {NG{pwm_out[0]}}) bad = 1;
         @(negedge clk);
      end
      chk(!bad, "R7", "clients in lockstep with host", int'(bad), 0);
      measure(0, p, h);
      chk(p == 10, "R5", "host runs back to back", p, 10);
   endtask

   task automatic t_shadow_update();
      int p, h; bit bad = 0;
      write_cfg(6, 0, 2, 0, 1'b0);
      measure(0, p, h);
      chk(p == 10 && h == 4, "R8", "unrequested write has no effect", p * 100 + h, 1004);
      @(negedge clk);
      upd_set = 1'b1;
      @(negedge clk);
      upd_set = 1'b0;
      for (int i = 0; i < 25; i++) begin
         if (soc_out != {NG{soc_out[0]}} || pwm_out != {NG{pwm_out[0]}}) bad = 1;
         @(negedge clk);
      end
      chk(!bad, "R10", "all switch on same cycle", int'(bad), 0);
      measure(1, p, h);
      chk(p == 6 && h == 2, "R10", "client uses new values", p * 100 + h, 602);
      measure(0, p, h);
      chk(p == 6 && h == 2, "R8", "host uses transferred values", p * 100 + h, 602);
   endtask

   task automatic t_duty_edges();
      int p, h;
      write_cfg(6, 0, 0, 0, 1'b1);
      measure(0, p, h);
      chk(h == 0, "R4", "zero duty stays low", h, 0);
      write_cfg(6, 0, 20, 0, 1'b1);
      measure(0, p, h);
      chk(h == 6, "R4", "duty above period stays high", h, 6);
   endtask

   task automatic t_host_off_late_join();
      int p, h; bit bad = 0; int guard = 0;
      gen_en = 3'b110;
      repeat (20) @(negedge clk);
      for (int i = 0; i < 20; i++) begin
         if (pwm_out != '0 || soc_out != '0) bad = 1;
         @(negedge clk);
      end
      chk(!bad, "R5", "disabled host stops after cycle", int'(bad), 0);
      write_cfg(8, 0, 3, 0, 1'b1);
      repeat (5) @(negedge clk);
      chk(upd_busy == 1'b1, "R9", "request pending while idle", int'(upd_busy), 1);
      gen_en = 3'b001;
      repeat (3) @(negedge clk);
      gen_en = 3'b101;
      while (!soc_out[2] && guard < 100) begin @(negedge clk); guard++; end
      chk(soc_out[0] == 1'b1, "R6", "late client starts with host", int'(soc_out[0]), 1);
      measure(2, p, h);
      chk(p == 8 && h == 3, "R2", "late client period and duty", p * 100 + h, 803);
      chk(pwm_out[1] == 1'b0 && soc_out[1] == 1'b0, "R6", "disabled client stays low",
          int'({soc_out[1], pwm_out[1]}), 0);
   endtask

   initial begin
      t_reset();
      t_start_lockstep();
      t_shadow_update();
      t_duty_edges();
      t_host_off_late_join();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule